// File: doc/BRIEF.md
# MDIO Management Frame Master

This block puts PHY management traffic on a two-wire serial management bus. Software writes a single 32-bit command word. The word carries a go bit, the raw start code, the opcode, the port address, a register or device field and sixteen data bits. The block then shifts one complete management frame out on the MDC clock and the MDIO data line. The frame is a 32-bit preamble of ones followed by the fields of the command, sent most significant bit first.

The start and opcode fields are placed on the wire exactly as written. One engine therefore produces ordinary register frames as well as the address, write and read frames of the extended device-addressed scheme. An extended access is issued by software as two commands. The first is an address frame that carries the register number. Once the busy bit has cleared, the second is a write or read frame to the same port and device. On a read, the sixteen bits returned by the PHY replace the low half of the command word.

Top module: `mdio_cmd_master`

## Requirements
- R1: A host write with bit 31 set, issued while the block is idle, launches a frame. Bit 31 of `cmd_rdata` reads 1 from the clock after the write until exactly HALF + 64*CLK_DIV clocks after that write, where HALF = CLK_DIV/2. At that point it reads 0, which is one MDC period after the last data bit.
- R2: Each frame is 64 bits long and is sampled on 64 rising MDC edges. In order, these are 32 ones, command bits 17:16 (start code), bits 19:18 (opcode), bits 24:20 (port address), bits 29:25 (register or device), two turnaround bits, and bits 15:0. Every field is sent MSB first, and the start and opcode values are sent unaltered.
- R3: For opcodes 00 and 01 the master drives MDIO on all 64 bits, with the turnaround sent as 1 then 0. For opcodes 10 and 11 (reads) the master drives bits 0 to 45 and releases `mdio_oe` for bits 46 to 63.
- R4: For a read, the 16 values on `mdio_i` at rising MDC edges 48 to 63 (MSB first) appear in `cmd_rdata[15:0]` once busy clears. Bits 30:16 keep the values written. For other opcodes, bits 30:0 keep the written command.
- R5: MDC has a period of CLK_DIV clocks while a frame runs. Its first rising edge comes HALF clocks after the launching write, and MDC is low whenever busy is 0.
- R6: A host write while busy is 1 is ignored. The frame on the wire and `cmd_rdata[30:0]` are unaffected.
- R7: `mdio_o` only changes in a clock after a rising MDC edge, never on the edge itself. `mdio_oe` is 0 whenever the block is idle, and after reset `cmd_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 32 | Command word written by the host |
| cmd_rdata | output | 32 | Command word read-back: bit 31 busy, low half holds read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the wire |

## Verification
Counting from the clock edge that accepts a command, the k-th rising MDC edge (k from 0) is due after HALF + k*CLK_DIV clocks. Busy clears at HALF + 64*CLK_DIV clocks, and the read data is valid from that same edge. The bench counts clocks from the accepting edge and looks at the outputs on falling clock edges. It records MDIO and the enable on the falling edge that first shows MDC high. It compares each rising-edge time, and the exact clock in which busy falls, against these formulas. The bench feeds PHY read bits one clock edge ahead of the rising MDC edge that samples them, so each bit is stable when it is captured.

// File: rtl/mdio_pkg.sv
// Package: shared constants, engine state type and frame builder for the
// MDIO master. Assumes the fixed 64-bit frame layout (32 preamble + 32 body).
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_FIRST   = 46;   // first turnaround bit index
    localparam int DATA_FIRST = 48;   // first data bit index
    localparam int DATA_BITS  = 16;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_TAIL  = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic [1:0]  start;
        logic [1:0]  opcode;
        logic [4:0]  port;
        logic [4:0]  regdev;
        logic [15:0] data;
    } mdio_cmd_t;

    // Unpack the command word fields that the frame uses.
    function automatic mdio_cmd_t unpack_cmd(input logic [31:0] w);
        mdio_cmd_t c;
        c.start  = w[17:16];
        c.opcode = w[19:18];
        c.port   = w[24:20];
        c.regdev = w[29:25];
        c.data   = w[15:0];
        return c;
    endfunction

    // An opcode with its upper bit set releases the line for the reply.
    function automatic logic is_read_op(input logic [1:0] op);
        return op[1];
    endfunction

    // Assemble the 64 bits of a frame, bit 63 sent first.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  ta;
        logic [15:0] body_data;
        ta        = is_read_op(c.opcode) ? 2'b00 : 2'b10;
        body_data = is_read_op(c.opcode) ? 16'h0000 : c.data;
        return {{PRE_BITS{1'b1}}, c.start, c.opcode, c.port, c.regdev, ta, body_data};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
// Module: MDC generator. Divides clk by an even CLK_DIV while run is high and
// flags the clock cycle just before each rising MDC edge. When last is high,
// the next rising edge is suppressed so that MDC stays low as the frame ends.
// Assumes CLK_DIV is even and at least 2; run and last come from registers.
module mdio_clk_div #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic last,
    output logic mdc,
    output logic rise_p
);

    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] WRAP = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;

    // Half-period counter and MDC toggle, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (cnt_q == WRAP) begin
            cnt_q <= '0;
            if (!(last && !mdc_q)) begin
                mdc_q <= ~mdc_q;
            end
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // The cycle whose closing edge is (or would be) a rising MDC edge.
    always_comb begin
        rise_p = run && (cnt_q == WRAP) && !mdc_q;
    end

    assign mdc = mdc_q;

endmodule

// File: rtl/mdio_frame_engine.sv
// Module: frame serialiser. Loads a 64-bit frame on start, presents one bit per
// MDC period, samples mdio_i on each rising MDC edge and moves to the next bit
// one clock after that edge. A tail state holds busy for one more MDC period.
// Assumes start only arrives while idle and rise_p comes from mdio_clk_div.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_p,
    input  logic        mdio_i,
    output logic        run,
    output logic        last,
    output logic        done,
    output logic        done_rd,
    output logic [15:0] rd_data,
    output logic        mdio_o,
    output logic        mdio_oe
);

    eng_state_t            st_q;
    logic [5:0]            idx_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic                  oe_q;
    logic                  rd_q;
    logic                  rise_d_q;
    logic [15:0]           cap_q;
    logic [5:0]            idx_nxt;

    always_comb begin
        idx_nxt = idx_q + 6'd1;
    end

    // Sequencer: load, bit advance, tail and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ENG_IDLE;
            idx_q    <= '0;
            sh_q     <= '0;
            oe_q     <= 1'b0;
            rd_q     <= 1'b0;
            rise_d_q <= 1'b0;
        end else begin
            rise_d_q <= rise_p;
            unique case (st_q)
                ENG_IDLE: begin
                    rise_d_q <= 1'b0;
                    if (start) begin
                        st_q  <= ENG_SHIFT;
                        idx_q <= '0;
                        sh_q  <= build_frame(cmd);
                        oe_q  <= 1'b1;
                        rd_q  <= is_read_op(cmd.opcode);
                    end
                end
                ENG_SHIFT: begin
                    if (rise_d_q) begin
                        if (idx_q == 6'(FRAME_BITS - 1)) begin
                            st_q <= ENG_TAIL;
                            oe_q <= 1'b0;
                        end else begin
                            idx_q <= idx_nxt;
                            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                            oe_q  <= !(rd_q && (idx_nxt >= 6'(TA_FIRST)));
                        end
                    end
                end
                ENG_TAIL: begin
                    if (rise_p) begin
                        st_q <= ENG_IDLE;
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    // Capture line: shift in mdio_i on every rising MDC edge of a read frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (st_q == ENG_SHIFT && rise_p && rd_q) begin
            cap_q <= {cap_q[14:0], mdio_i};
        end
    end

    // Status and line outputs derived from registers.
    always_comb begin
        run     = (st_q != ENG_IDLE);
        last    = (st_q == ENG_TAIL);
        done    = (st_q == ENG_TAIL) && rise_p;
        done_rd = rd_q;
        rd_data = cap_q;
        mdio_o  = sh_q[FRAME_BITS-1];
        mdio_oe = oe_q;
    end

endmodule

// File: rtl/mdio_cmd_master.sv
// Module: top of the MDIO master. Holds the command word and accepts a host
// write only when bit 31 is set and no frame is running. It feeds the frame
// engine and the MDC divider, and folds read data back into the low half.
// Assumes a single host writer; writes while busy or with bit 31 clear are dropped.
module mdio_cmd_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic [30:0] cmd_q;
    logic        accept;
    logic        run;
    logic        last;
    logic        done;
    logic        done_rd;
    logic        rise_p;
    logic [15:0] rd_data;
    mdio_cmd_t   cmd_fields;

    // Launch decode: go bit set and engine idle.
    always_comb begin
        accept     = cmd_wr && cmd_wdata[31] && !run;
        cmd_fields = unpack_cmd(cmd_wdata);
    end

    // Command word storage and read-data write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_wdata[30:0];
        end else if (done && done_rd) begin
            cmd_q[15:0] <= rd_data;
        end
    end

    mdio_clk_div #(
        .CLK_DIV (CLK_DIV)
    ) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .last   (last),
        .mdc    (mdc),
        .rise_p (rise_p)
    );

    mdio_frame_engine i_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .cmd     (cmd_fields),
        .rise_p  (rise_p),
        .mdio_i  (mdio_i),
        .run     (run),
        .last    (last),
        .done    (done),
        .done_rd (done_rd),
        .rd_data (rd_data),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    assign cmd_rdata = {run, cmd_q};

endmodule

// File: rtl/mdio_cmd_master_chk.sv
// Module: property checker for mdio_cmd_master, attached by bind below.
// Observes only the top-level ports.
module mdio_cmd_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [31:0] cmd_wdata,
    input logic [31:0] cmd_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    // R1: a go write while idle raises busy on the next clock.
    assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rdata[31] && cmd_wr && cmd_wdata[31]) |=> cmd_rdata[31]);

    // R5: MDC is low whenever the block is idle.
    assert_mdc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[31] |-> !mdc);

    // R6: fields of the command stay put while a frame runs.
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[31] && cmd_wr) |=> $stable(cmd_rdata[30:16]));

    // R7: the line does not change on a rising MDC edge.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o));

    // R7: output enable is released while idle.
    assert_oe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[31] |-> !mdio_oe);

endmodule

bind mdio_cmd_master mdio_cmd_master_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/test_mdio_cmd_master.sv
// Bench: directed and seeded-random frames against an in-bench PHY model.
module test_mdio_cmd_master;

    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;
    localparam int LAT  = HALF + 64 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    mdio_cmd_master #(.CLK_DIV(DIV)) i_mdio_cmd_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .cmd_rdata (cmd_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    function automatic logic [63:0] exp_frame(input logic [31:0] c);
        logic [1:0]  ta;
        logic [15:0] d;
        ta = c[19] ? 2'b00 : 2'b10;
        d  = c[19] ? 16'h0 : c[15:0];
        return {32'hFFFF_FFFF, c[17:16], c[19:18], c[24:20], c[29:25], ta, d};
    endfunction

    function automatic logic [63:0] exp_oe(input logic [31:0] c);
        logic [63:0] m;
        for (int i = 0; i < 64; i++) m[63-i] = !(c[19] && i >= 46);
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [31:0] cmd, input logic [15:0] rd_val,
                             input bit poke);
        logic [63:0] got = '0;
        logic [63:0] oeg = '0;
        logic [63:0] ef, eo;
        logic [31:0] exp_rb;
        int  rises = 0;
        bit  prev = 1'b0;
        bit  time_ok = 1'b1;
        bit  busy_ok = 1'b1;
        ef = exp_frame(cmd);
        eo = exp_oe(cmd);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = cmd;
        @(negedge clk);
        cmd_wr = 1'b0;
        for (int n = 0; n < LAT; n++) begin
            if (!cmd_rdata[31]) busy_ok = 1'b0;
            if (mdc && !prev) begin
                if (rises < 64) begin
                    got[63-rises] = mdio_o;
                    oeg[63-rises] = mdio_oe;
                end
                if (n != HALF + rises * DIV) time_ok = 1'b0;
                rises++;
                if (rises >= 48 && rises <= 63) mdio_i = rd_val[63-rises];
                else mdio_i = 1'($urandom);
            end
            prev = mdc;
            if (poke && n == 200) begin
                cmd_wr = 1'b1;
                cmd_wdata = ~cmd | 32'h8000_0000;
            end else begin
                cmd_wr = 1'b0;
            end
            @(negedge clk);
        end
        exp_rb = {1'b0, cmd[30:16], cmd[19] ? rd_val : cmd[15:0]};
        // R1: busy held for the whole frame and clear exactly at LAT
        check(busy_ok && !cmd_rdata[31], "R1 busy window", {63'd0, cmd_rdata[31]}, 64'd0);
        // R2: every driven bit matches the command fields
        check(((got ^ ef) & eo) == 64'd0, "R2 frame bits", got & eo, ef & eo);
        // R3: enable pattern and turnaround
        check(oeg == eo, "R3 output enable", oeg, eo);
        // R5: rising edge times and count
        check(time_ok && rises == 64, "R5 mdc timing", 64'(rises), 64'd64);
        // R5/R7: idle state of the lines after completion
        check(!mdc && !mdio_oe, "R7 idle lines", {62'd0, mdc, mdio_oe}, 64'd0);
        // R4/R6: read-back word (read data, or the command kept despite poke)
        check(cmd_rdata == exp_rb, poke ? "R6 write ignored" : "R4 read-back",
              64'(cmd_rdata), 64'(exp_rb));
    endtask

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        check(cmd_rdata == 32'd0 && !mdc && !mdio_oe, "R7 reset state",
              64'(cmd_rdata), 64'd0);
        // R1: write with go bit clear starts nothing
        cmd_wr = 1'b1;
        cmd_wdata = 32'h7FFF_FFFF;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (DIV) @(negedge clk);
        check(!cmd_rdata[31] && !mdc, "R1 no go", 64'(cmd_rdata[31]), 64'd0);

        // Directed: register write all ones, register read, extended sequence
        run_frame({1'b1, 1'b0, 5'd31, 5'd31, 2'b01, 2'b01, 16'hFFFF}, 16'h0, 1'b0);
        run_frame({1'b1, 1'b0, 5'd2, 5'd1, 2'b10, 2'b01, 16'h0000}, 16'hA5C3, 1'b0);
        run_frame({1'b1, 1'b0, 5'd1, 5'd3, 2'b00, 2'b00, 16'h1234}, 16'h0, 1'b0);
        run_frame({1'b1, 1'b0, 5'd1, 5'd3, 2'b11, 2'b00, 16'h0000}, 16'h8001, 1'b0);
        run_frame({1'b1, 1'b0, 5'd1, 5'd3, 2'b01, 2'b00, 16'h0000}, 16'h0, 1'b0);
        // R6: writes while busy on both a write and a read frame
        run_frame({1'b1, 1'b1, 5'd9, 5'd4, 2'b01, 2'b01, 16'h5A5A}, 16'h0, 1'b1);
        run_frame({1'b1, 1'b0, 5'd9, 5'd4, 2'b10, 2'b01, 16'h0000}, 16'hFFFF, 1'b1);

        // Seeded random frames
        for (int k = 0; k < 12; k++) begin
            logic [31:0] c;
            c = $urandom;
            c[31] = 1'b1;
            c[17] = 1'b0;
            run_frame(c, 16'($urandom), (k % 4) == 3);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule